// File: doc/BRIEF.md
# Biosignal Front-End Command Controller

This block sits between a host-side byte queue and a byte-wide SPI master that serves a multichannel biopotential acquisition chip. It pulls a command packet from the queue. A packet is one opcode byte, then an optional argument byte, then any data bytes. The controller decodes the packet into one of three SPI flows: a register read burst, a register write burst, or continuous sample streaming. Single-byte control opcodes (wakeup, standby, reset, stop) are sent as one-byte transfers. Bytes read back from the chip reach the host through a strobe/acknowledge handshake, and `host_stall` stays high for the whole of each transaction so that further host requests wait.

The queue is show-ahead: `fifo_data` is the head byte whenever `fifo_empty` is low, and `fifo_rd` pops it. Each SPI byte begins with a one-cycle `spi_start` and ends when the master pulses `spi_done`, with the received byte on `spi_rx`. Opcode classes are as follows. Bits [7:5] = 001 is a register read whose low five bits are the first address. Bits [7:5] = 010 is a register write. 0x10 starts streaming, 0x11 stops it, and 0x02, 0x04 and 0x06 are wakeup, standby and reset. Every other value is rejected. For a read or write, the argument byte holds the register count minus one. For 0x10 it holds a decimation value D: after each captured frame, the controller ignores the next D data-ready falling edges.

The state machine has the states IDLE, ARG, XFER, SPIW, WDATA, RET, END and STREAM. IDLE pops and classifies an opcode: a single opcode goes to XFER, an opcode with an argument goes to ARG, and a rejected opcode stays in IDLE with an error pulse. ARG pops the argument and goes to XFER. XFER issues one SPI byte and goes to SPIW. SPIW waits for completion and then chooses between XFER (the argument byte or the next read dummy), WDATA (fetch a write byte), RET (hand a read byte to the host) and END. RET waits for the host acknowledge and then goes to XFER or END. END raises chip select for a cycle and goes to IDLE, or to STREAM after a start or a frame. STREAM waits for a data-ready edge, which leads to XFER for a frame, or for a stop opcode at the queue head, which leads to XFER for the stop byte.

Top module: `biosig_cmd_ctrl`

## Requirements
- R1: During and right after reset, `cs_n`=1, `host_stall`=0, and `fifo_rd`, `spi_start`, `ret_stb` and `err_flag` are all 0.
- R2: A register read (opcode 001xxxxx, argument N) sends over SPI the opcode, then N, then N+1 bytes of 0x00. The bytes received during the N+1 dummy transfers are passed to the host in order.
- R3: A register write (opcode 010xxxxx, argument N) sends the opcode, then N, then N+1 further bytes popped from the queue, in queue order. Nothing is returned to the host.
- R4: Opcodes 0x02, 0x04, 0x06, and 0x11 outside streaming, each produce exactly one SPI byte equal to the opcode and nothing for the host.
- R5: Any other opcode is popped and raises `err_flag` for one cycle. It causes no SPI transfer and no chip-select activity, and the next packet is processed normally.
- R6: `cs_n` falls only in a cycle that starts an SPI byte, and stays low until the transaction's last byte completes. Each command or frame forms exactly one chip-select low period.
- R7: `host_stall` is high whenever `cs_n` is low, and low while idle or while waiting between stream frames.
- R8: `ret_stb` with `ret_dat`, once raised, holds steady until `ret_ack` is seen.
- R9: Opcode 0x10 with argument D sends 0x10 and enters streaming. The first falling edge of `drdy_n` after that, and every (D+1)-th edge thereafter, produces one frame of `FRAME_BYTES` 0x00 transfers whose received bytes go to the host.
- R10: While streaming, a 0x11 at the queue head is popped and sent as one SPI byte, and streaming ends. Later `drdy_n` edges produce no transfers.
- R11: `fifo_rd` is asserted only while `fifo_empty` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_empty | input | 1 | Command queue has no byte |
| fifo_data | input | 8 | Head byte of the command queue |
| fifo_rd | output | 1 | Pop the head byte |
| spi_start | output | 1 | One-cycle request to shift `spi_tx` |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | One-cycle pulse: byte exchange complete |
| spi_rx | input | 8 | Byte received, valid with `spi_done` |
| cs_n | output | 1 | Chip select, active low |
| drdy_n | input | 1 | Sample-ready from the chip, active low |
| ret_stb | output | 1 | Return byte valid toward the host |
| ret_dat | output | 8 | Return byte |
| ret_ack | input | 1 | Host accepted the return byte |
| host_stall | output | 1 | Transaction in progress |
| err_flag | output | 1 | One-cycle pulse on a rejected opcode |

## Verification
The bound assertions check on every cycle the relationships that hold locally in time. Chip select may fall only with a transfer start, and the stall flag must cover every cycle with chip select low. The return strobe and its byte must hold until acknowledged. A pop must never hit an empty queue, and a rejected opcode must never coincide with chip-select or SPI activity. Only the bench scenarios can show that each flow sends the right byte sequence and count, and that read data reaches the host in order. They also show the decimation spacing of frames, that stop ends streaming, and that each command occupies exactly one chip-select period.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE, S_ARG, S_XFER, S_SPIW, S_WDATA, S_RET, S_END, S_STREAM
    } state_t;

    typedef enum logic [2:0] {
        K_NONE, K_SINGLE, K_RREG, K_WREG, K_START, K_FRAME, K_BAD
    } kind_t;

    typedef enum logic [1:0] {
        P_OP, P_ARG, P_DATA
    } phase_t;

    localparam logic [BYTE_W-1:0] OP_WAKE  = 8'h02;
    localparam logic [BYTE_W-1:0] OP_STBY  = 8'h04;
    localparam logic [BYTE_W-1:0] OP_RST   = 8'h06;
    localparam logic [BYTE_W-1:0] OP_START = 8'h10;
    localparam logic [BYTE_W-1:0] OP_STOP  = 8'h11;
endpackage

// File: rtl/bcc_opdec.sv
module bcc_opdec
    import bcc_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output kind_t             kind
);
    always_comb begin
        if (op[7:5] == 3'b001)
            kind = K_RREG;
        else if (op[7:5] == 3'b010)
            kind = K_WREG;
        else if (op == OP_START)
            kind = K_START;
        else if (op == OP_STOP || op == OP_STBY || op == OP_RST || op == OP_WAKE)
            kind = K_SINGLE;
        else
            kind = K_BAD;
    end
endmodule

// File: rtl/bcc_frame_gate.sv
module bcc_frame_gate #(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drdy_n,
    input  logic          load,
    input  logic [IW-1:0] interval,
    input  logic          en,
    output logic          go
);
    logic          drdy_q;
    logic [IW-1:0] ival_q;
    logic [IW-1:0] skip_q;
    logic          fall;

    assign fall = drdy_q && !drdy_n;
    assign go   = fall && (skip_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy_q <= 1'b1;
            ival_q <= '0;
            skip_q <= '0;
        end else begin
            drdy_q <= drdy_n;
            if (load) begin
                ival_q <= interval;
                skip_q <= '0;
            end else if (en && fall) begin
                skip_q <= (skip_q == '0) ? ival_q : skip_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/biosig_cmd_ctrl.sv
module biosig_cmd_ctrl
    import bcc_pkg::*;
#(
    parameter int FRAME_BYTES = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_rd,
    output logic              spi_start,
    output logic [BYTE_W-1:0] spi_tx,
    input  logic              spi_done,
    input  logic [BYTE_W-1:0] spi_rx,
    output logic              cs_n,
    input  logic              drdy_n,
    output logic              ret_stb,
    output logic [BYTE_W-1:0] ret_dat,
    input  logic              ret_ack,
    output logic              host_stall,
    output logic              err_flag
);
    localparam int CNT_MAX = (FRAME_BYTES > 256) ? FRAME_BYTES : 256;
    localparam int CW      = $clog2(CNT_MAX);

    state_t            state_q, state_d;
    kind_t             kind_q, kind_d, dec_kind;
    phase_t            phase_q, phase_d;
    logic [BYTE_W-1:0] arg_q, arg_d, tx_q, tx_d, rx_q, rx_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic              gate_load, gate_en, frame_go, stop_hit;

    bcc_opdec u_dec (.op(fifo_data), .kind(dec_kind));

    assign stop_hit = !fifo_empty && (fifo_data == OP_STOP);
    assign gate_en  = (state_q == S_STREAM) && !stop_hit;

    bcc_frame_gate #(.IW(BYTE_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n),
        .load(gate_load), .interval(fifo_data),
        .en(gate_en), .go(frame_go)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= K_NONE;
            phase_q <= P_OP;
            arg_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            phase_q <= phase_d;
            arg_q   <= arg_d;
            tx_q    <= tx_d;
            rx_q    <= rx_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and queue pops
    always_comb begin
        state_d   = state_q;
        kind_d    = kind_q;
        phase_d   = phase_q;
        arg_d     = arg_q;
        tx_d      = tx_q;
        rx_d      = rx_q;
        cnt_d     = cnt_q;
        fifo_rd   = 1'b0;
        err_flag  = 1'b0;
        gate_load = 1'b0;
        unique case (state_q)
            S_IDLE: if (!fifo_empty) begin
                fifo_rd = 1'b1;
                kind_d  = dec_kind;
                tx_d    = fifo_data;
                phase_d = P_OP;
                unique case (dec_kind)
                    K_SINGLE:               state_d = S_XFER;
                    K_RREG, K_WREG, K_START: state_d = S_ARG;
                    default:                err_flag = 1'b1;
                endcase
            end
            S_ARG: if (!fifo_empty) begin
                fifo_rd   = 1'b1;
                arg_d     = fifo_data;
                gate_load = (kind_q == K_START);
                state_d   = S_XFER;
            end
            S_XFER: state_d = S_SPIW;
            S_SPIW: if (spi_done) begin
                rx_d = spi_rx;
                unique case (phase_q)
                    P_OP: if (kind_q == K_RREG || kind_q == K_WREG) begin
                        phase_d = P_ARG;
                        tx_d    = arg_q;
                        state_d = S_XFER;
                    end else begin
                        state_d = S_END;
                    end
                    P_ARG: begin
                        cnt_d   = CW'(arg_q);
                        phase_d = P_DATA;
                        tx_d    = '0;
                        state_d = (kind_q == K_RREG) ? S_XFER : S_WDATA;
                    end
                    default: if (kind_q == K_WREG) begin
                        if (cnt_q == '0) begin
                            state_d = S_END;
                        end else begin
                            cnt_d   = cnt_q - 1'b1;
                            state_d = S_WDATA;
                        end
                    end else begin
                        state_d = S_RET;
                    end
                endcase
            end
            S_WDATA: if (!fifo_empty) begin
                fifo_rd = 1'b1;
                tx_d    = fifo_data;
                state_d = S_XFER;
            end
            S_RET: if (ret_ack) begin
                if (cnt_q == '0) begin
                    state_d = S_END;
                end else begin
                    cnt_d   = cnt_q - 1'b1;
                    tx_d    = '0;
                    state_d = S_XFER;
                end
            end
            S_END: state_d = (kind_q == K_START || kind_q == K_FRAME) ? S_STREAM : S_IDLE;
            S_STREAM: if (stop_hit) begin
                fifo_rd = 1'b1;
                kind_d  = K_SINGLE;
                phase_d = P_OP;
                tx_d    = OP_STOP;
                state_d = S_XFER;
            end else if (frame_go) begin
                kind_d  = K_FRAME;
                phase_d = P_DATA;
                cnt_d   = CW'(FRAME_BYTES - 1);
                tx_d    = '0;
                state_d = S_XFER;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        spi_start  = (state_q == S_XFER);
        spi_tx     = tx_q;
        cs_n       = !(state_q == S_XFER || state_q == S_SPIW ||
                       state_q == S_WDATA || state_q == S_RET);
        host_stall = !(state_q == S_IDLE || state_q == S_STREAM);
        ret_stb    = (state_q == S_RET);
        ret_dat    = rx_q;
    end
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_empty,
    input logic       fifo_rd,
    input logic       spi_start,
    input logic       cs_n,
    input logic       host_stall,
    input logic       ret_stb,
    input logic       ret_ack,
    input logic [7:0] ret_dat,
    input logic       err_flag
);
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);                                        // R11
    AST_CS_FALL_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> spi_start);                                      // R6
    AST_CS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> host_stall);                                           // R7
    AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_stb && !ret_ack) |=> (ret_stb && $stable(ret_dat)));        // R8
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (cs_n && !spi_start));                              // R5
endmodule

bind biosig_cmd_ctrl bcc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
    .spi_start(spi_start), .cs_n(cs_n), .host_stall(host_stall),
    .ret_stb(ret_stb), .ret_ack(ret_ack), .ret_dat(ret_dat),
    .err_flag(err_flag)
);

// File: tb/biosig_cmd_ctrl_test.sv
module biosig_cmd_ctrl_test;
    localparam int FRAME = 27;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_empty = 1'b1;
    logic [7:0] fifo_data = 8'h00;
    logic       fifo_rd, spi_start, cs_n, ret_stb, host_stall, err_flag;
    logic [7:0] spi_tx, ret_dat;
    logic       spi_done = 1'b0;
    logic [7:0] spi_rx = 8'h00;
    logic       drdy_n = 1'b1;
    logic       ret_ack = 1'b0;

    always #5 clk = ~clk;

    biosig_cmd_ctrl #(.FRAME_BYTES(FRAME)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_rd(fifo_rd), .spi_start(spi_start), .spi_tx(spi_tx),
        .spi_done(spi_done), .spi_rx(spi_rx), .cs_n(cs_n), .drdy_n(drdy_n),
        .ret_stb(ret_stb), .ret_dat(ret_dat), .ret_ack(ret_ack),
        .host_stall(host_stall), .err_flag(err_flag)
    );

    logic [7:0] fq[$];
    logic [7:0] tx_log[$];
    logic [7:0] host_log[$];
    logic [7:0] exp_tx[$];
    logic [7:0] exp_host[$];
    int         spi_cnt = 0;
    logic [7:0] rx_val = 8'h30;
    int         err_cnt = 0;
    int         cs_falls = 0;
    logic       cs_prev = 1'b1;
    logic       stb_prev = 1'b0;
    logic       ack_prev = 1'b0;
    logic [7:0] dat_prev = 8'h00;
    int         tests = 0;
    int         fails = 0;
    bit         sd;
    bit         finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // behavioural queue, SPI responder and host sink
    always @(posedge clk) begin
        if (fifo_rd && fq.size() > 0) void'(fq.pop_front());
        fifo_empty <= (fq.size() == 0);
        fifo_data  <= (fq.size() > 0) ? fq[0] : 8'h00;
        sd = 1'b0;
        if (spi_start) begin
            tx_log.push_back(spi_tx);
            spi_cnt = 3;
        end else if (spi_cnt > 0) begin
            spi_cnt--;
            if (spi_cnt == 0) sd = 1'b1;
        end
        spi_done <= sd;
        if (sd) begin
            spi_rx <= rx_val;
            rx_val = rx_val + 8'd1;
        end
        if (ret_ack) ret_ack <= 1'b0;
        else if (ret_stb) begin
            ret_ack <= 1'b1;
            host_log.push_back(ret_dat);
        end
    end

    // per-cycle comparisons against the requirements
    always @(negedge clk) begin
        if (rst_n) begin
            check(cs_n || host_stall, "R7 stall while cs low", int'(host_stall), 1);
            check(!(fifo_rd && fifo_empty), "R11 pop on empty", int'(fifo_rd), 0);
            if (stb_prev && !ack_prev)
                check(ret_stb && ret_dat == dat_prev, "R8 return hold", int'(ret_dat), int'(dat_prev));
            if (cs_prev && !cs_n) cs_falls++;
            if (err_flag) err_cnt++;
        end
        cs_prev  = cs_n;
        stb_prev = ret_stb;
        ack_prev = ret_ack;
        dat_prev = ret_dat;
    end

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        fq.push_back(b);
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 4) begin
            @(negedge clk);
            if (fq.size() == 0 && cs_n && !host_stall && !ret_stb && spi_cnt == 0) q++;
            else q = 0;
        end
    endtask

    task automatic clear_logs();
        tx_log.delete(); host_log.delete(); exp_tx.delete(); exp_host.delete();
        cs_falls = 0; err_cnt = 0;
    endtask

    task automatic compare(input string req);
        check(tx_log.size() == exp_tx.size(), {req, " SPI byte count"}, tx_log.size(), exp_tx.size());
        for (int i = 0; i < exp_tx.size() && i < tx_log.size(); i++)
            if (tx_log[i] != exp_tx[i])
                check(1'b0, {req, " SPI byte"}, int'(tx_log[i]), int'(exp_tx[i]));
        check(host_log.size() == exp_host.size(), {req, " host byte count"}, host_log.size(), exp_host.size());
        for (int i = 0; i < exp_host.size() && i < host_log.size(); i++)
            if (host_log[i] != exp_host[i])
                check(1'b0, {req, " host byte"}, int'(host_log[i]), int'(exp_host[i]));
    endtask

    task automatic drdy_pulse();
        @(negedge clk);
        drdy_n = 1'b0;
        repeat (3) @(negedge clk);
        drdy_n = 1'b1;
        wait_quiet();
    endtask

    initial begin
        logic [7:0] base;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cs_n && !host_stall && !fifo_rd && !spi_start && !ret_stb && !err_flag,
              "R1 reset outputs", int'({cs_n, host_stall, fifo_rd, spi_start, ret_stb, err_flag}), 32);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n && !host_stall && !ret_stb, "R1 after reset", int'(cs_n), 1);

        // R2 register read, three registers from 0x03
        clear_logs(); base = rx_val;
        push(8'h23); push(8'h02); wait_quiet();
        exp_tx = '{8'h23, 8'h02, 8'h00, 8'h00, 8'h00};
        for (int i = 0; i < 3; i++) exp_host.push_back(base + 8'(2 + i));
        compare("R2");
        check(cs_falls == 1, "R6 one cs period (read)", cs_falls, 1);

        // R2 boundary: single register
        clear_logs(); base = rx_val;
        push(8'h20); push(8'h00); wait_quiet();
        exp_tx = '{8'h20, 8'h00, 8'h00};
        exp_host.push_back(base + 8'd2);
        compare("R2 single");

        // R3 register write, two registers
        clear_logs();
        push(8'h45); push(8'h01); push(8'hAA); push(8'hBB); wait_quiet();
        exp_tx = '{8'h45, 8'h01, 8'hAA, 8'hBB};
        compare("R3");
        check(cs_falls == 1, "R6 one cs period (write)", cs_falls, 1);

        // R4 single-byte opcodes
        clear_logs();
        push(8'h04); wait_quiet(); push(8'h06); wait_quiet();
        push(8'h02); wait_quiet(); push(8'h11); wait_quiet();
        exp_tx = '{8'h04, 8'h06, 8'h02, 8'h11};
        compare("R4");
        check(cs_falls == 4, "R6 cs period per opcode", cs_falls, 4);

        // R5 rejected opcodes, then a valid packet
        clear_logs();
        push(8'hFF); wait_quiet(); push(8'h00); wait_quiet();
        check(err_cnt == 2, "R5 error pulses", err_cnt, 2);
        check(tx_log.size() == 0 && cs_falls == 0, "R5 no SPI activity", tx_log.size(), 0);
        push(8'h04); wait_quiet();
        exp_tx = '{8'h04};
        compare("R5 recovery");

        // R9 streaming with decimation 1
        clear_logs(); base = rx_val;
        push(8'h10); push(8'h01); wait_quiet();
        check(!host_stall && cs_n, "R7 idle between frames", int'(host_stall), 0);
        for (int p = 0; p < 4; p++) drdy_pulse();
        exp_tx.push_back(8'h10);
        for (int i = 0; i < 2 * FRAME; i++) begin
            exp_tx.push_back(8'h00);
            exp_host.push_back(base + 8'(1 + i));
        end
        compare("R9 decimate");
        check(cs_falls == 3, "R9 frame cs periods", cs_falls, 3);

        // R10 stop, then data-ready is ignored
        clear_logs();
        push(8'h11); wait_quiet();
        drdy_pulse(); drdy_pulse();
        exp_tx = '{8'h11};
        compare("R10");

        // R9 streaming with no decimation
        clear_logs(); base = rx_val;
        push(8'h10); push(8'h00); wait_quiet();
        for (int p = 0; p < 2; p++) drdy_pulse();
        exp_tx.push_back(8'h10);
        for (int i = 0; i < 2 * FRAME; i++) begin
            exp_tx.push_back(8'h00);
            exp_host.push_back(base + 8'(1 + i));
        end
        compare("R9 every edge");
        clear_logs();
        push(8'h11); wait_quiet();
        exp_tx = '{8'h11};
        compare("R10 second stop");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule